// File: doc/BRIEF.md
# Line-Scan Sensor Readout Controller

This block sits on the host side of a 128-pixel line-scan image sensor and produces every timing signal the sensor needs. It divides the system clock down to the sensor clock and issues the line-start pulse. It marks the moment at which an external ADC should sample each pixel voltage and reports the matching pixel number. Lines repeat back to back while `run` is high. The spacing between line starts, counted in sensor-clock rising edges, sets the integration time of every pixel.

A line begins on the rising sensor-clock edge that samples `scan_start` high. That edge and the following 127 edges each present one pixel. A 129th edge carries no pixel; it is only there to close the cycle inside the sensor. A new start may be sampled on the 130th edge at the earliest. The divider and the line period are both clamped, so that no programmed value can break the maximum sensor-clock rate or this restart rule.

Pixel sample requests form a valid-only stream: `pix_valid` is a single-cycle pulse, and `pix_index` holds its value until the next pulse. There is no ready input and no back-pressure, because the sensor cannot be paused. The consumer must take every pulse in the cycle it is asserted.

Top module: `lscan_readout`

## Requirements
- R1: While `rst_n` is low, `scan_clk`, `scan_start`, `pix_valid`, `frame_start` and `frame_done` are 0 and `pix_index` is 0.
- R2: Within a line, every high and low phase of `scan_clk` lasts max(`half_div`, MIN_HALF) system cycles, where MIN_HALF = ceil(SYS_HZ / (2 * MAX_SCLK_HZ)), so the sensor clock never exceeds MAX_SCLK_HZ.
- R3: `scan_start` changes only together with a falling edge of `scan_clk`, and each high pulse spans exactly one rising edge of `scan_clk`.
- R4: `frame_done` is a one-cycle pulse in the first cycle that `scan_clk` is high for the 129th rising edge of a line (the start edge is edge 1), and it is never asserted at any other time.
- R5: For edges 1 to 128 of a line, `pix_valid` pulses for one cycle exactly SMP_DLY system cycles after `scan_clk` goes high, with `pix_index` equal to the edge number. Edge 129 gives no pulse, so a line has exactly 128 pulses, indexed 1 to 128 in order.
- R6: While `run` stays high, the next line start is sampled on edge number max(`line_period`, 130) of the current line. The spacing between starts is therefore max(`line_period`, 130) - 1 rising edges, and a value below 130 behaves as 130.
- R7: After `run` goes low, no new line starts. A line already started completes all 129 edges. `scan_clk` then stops at 0, with no further rising edge.
- R8: `frame_start` is a one-cycle pulse in the first cycle that `scan_clk` is high on the edge that samples `scan_start` high, and it is never asserted at any other time.
- R9: `pix_valid` is never high for two consecutive cycles, and SMP_DLY must be below 2*MIN_HALF so that each sample request comes before the next sensor-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Keep issuing lines while high |
| half_div | input | DIV_W | Sensor-clock half period in system cycles (clamped to MIN_HALF) |
| line_period | input | LP_W | Rising edges from one line start to the next (clamped to 130) |
| scan_clk | output | 1 | Sensor clock |
| scan_start | output | 1 | Sensor line-start pulse |
| pix_valid | output | 1 | ADC sample request, one cycle per pixel |
| pix_index | output | $clog2(NPIX+1) | Pixel number 1..128 for the current request |
| frame_start | output | 1 | One-cycle pulse on the start edge of a line |
| frame_done | output | 1 | One-cycle pulse on the terminating 129th edge |

## Verification
The bench builds the controller with SYS_HZ = 40 MHz and MAX_SCLK_HZ = 5 MHz, which gives a MIN_HALF of 4 system cycles, and with SMP_DLY = 3. This short floor lets one run cover both sides of the divider clamp, with half periods of 4, 5 and 7 cycles. A whole line then takes only about a thousand system cycles, so several back-to-back lines fit easily. Line periods of 50, 130, 200 and 300 exercise the restart clamp at and below 130 as well as spacings far beyond it. A stop in the middle of a line checks that the line in progress still completes.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

  // Sensor-clock phase events, each valid for one system cycle
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_tick_t;

  // Smallest half period (system cycles) that keeps the sensor clock legal
  function automatic int half_floor(input longint sys_hz, input longint max_hz);
    longint num;
    num = sys_hz + 2 * max_hz - 1;
    return int'(num / (2 * max_hz));
  endfunction

endpackage

// File: rtl/lscan_clkgen.sv
module lscan_clkgen
  import lscan_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output sclk_tick_t       tick
);

  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_eff;
  logic             wrap;

  assign half_eff = (half_div < MIN_H) ? MIN_H : half_div;
  assign wrap     = en && (cnt >= half_eff - 1'b1);

  always_comb begin
    tick.rise = wrap && !sclk;
    tick.fall = wrap &&  sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $past(en)) |-> ($past(cnt) >= MIN_H - 1'b1)); // R2

endmodule

// File: rtl/lscan_seq.sv
module lscan_seq
  import lscan_pkg::*;
#(
  parameter int NPIX  = 128,
  parameter int LP_W  = 12,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LP_W-1:0]  line_period,
  input  sclk_tick_t       tick,
  output logic             si,
  output logic             busy,
  output logic             ev_start,
  output logic             ev_pix,
  output logic [IDX_W-1:0] ev_num,
  output logic             ev_done
);

  localparam logic [LP_W-1:0] NPIX_L   = LP_W'(NPIX);
  localparam logic [LP_W-1:0] LINE_MIN = LP_W'(NPIX + 2);
  localparam logic [LP_W-1:0] ECNT_MAX = '1;

  logic [LP_W-1:0] ecnt;       // rising edges of current line, 0 = idle
  logic [LP_W-1:0] period_eff;
  logic            start_cond;
  logic            idle_exit;
  logic            fall_w;

  assign period_eff = (line_period < LINE_MIN) ? LINE_MIN : line_period;
  assign fall_w     = tick.fall;

  // Raise the start line on a falling edge so it is stable around one rise
  assign start_cond = run && !si && ((ecnt == '0) || (ecnt >= period_eff - 1'b1));
  assign idle_exit  = !run && !si && (ecnt > NPIX_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt <= '0;
      si   <= 1'b0;
    end else begin
      if (tick.rise) begin
        if (si) begin
          ecnt <= LP_W'(1);
        end else if ((ecnt != '0) && (ecnt != ECNT_MAX)) begin
          ecnt <= ecnt + 1'b1;
        end
      end
      if (tick.fall) begin
        si <= start_cond;
        if (idle_exit) begin
          ecnt <= '0;
        end
      end
    end
  end

  assign busy     = si || (ecnt != '0);
  assign ev_start = tick.rise && si;
  assign ev_pix   = tick.rise && (si || ((ecnt != '0) && (ecnt < NPIX_L)));
  assign ev_num   = si ? IDX_W'(1) : IDX_W'(ecnt + 1'b1);
  assign ev_done  = tick.rise && !si && (ecnt == NPIX_L);

  AST_SI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(si) |-> $past(fall_w)); // R3

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> (($past(ecnt) == '0) || ($past(ecnt) > NPIX_L))); // R6

  AST_NO_START_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> $past(run)); // R7

endmodule

// File: rtl/lscan_strobe.sv
module lscan_strobe #(
  parameter int IDX_W   = 8,
  parameter int SMP_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] num,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_index
);

  localparam int CNT_W = $clog2(SMP_DLY + 1);
  localparam logic [CNT_W-1:0] DLY_L = CNT_W'(SMP_DLY);
  localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

  logic [CNT_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt      <= '0;
      pix_valid <= 1'b0;
      pix_index <= '0;
    end else begin
      pix_valid <= (dcnt == ONE_L);
      if (load) begin
        dcnt      <= DLY_L;
        pix_index <= num;
      end else if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (dcnt <= ONE_L)); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid); // R9

endmodule

// File: rtl/lscan_readout.sv
module lscan_readout
  import lscan_pkg::*;
#(
  parameter longint SYS_HZ      = 125_000_000,
  parameter longint MAX_SCLK_HZ = 5_000_000,
  parameter int     NPIX        = 128,
  parameter int     DIV_W       = 8,
  parameter int     LP_W        = 12,
  parameter int     SMP_DLY     = 4,
  localparam int    IDX_W       = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  input  logic [LP_W-1:0]  line_period,
  output logic             scan_clk,
  output logic             scan_start,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_index,
  output logic             frame_start,
  output logic             frame_done
);

  localparam int MIN_HALF = half_floor(SYS_HZ, MAX_SCLK_HZ);
  localparam logic [IDX_W-1:0] NPIX_I = IDX_W'(NPIX);

  sclk_tick_t       tick;
  logic             busy;
  logic             sclk_en;
  logic             ev_start;
  logic             ev_pix;
  logic             ev_done;
  logic [IDX_W-1:0] ev_num;

  // Keep the clock running until it is low and no line is pending
  assign sclk_en = run || busy || scan_clk;

  lscan_clkgen #(
    .DIV_W    (DIV_W),
    .MIN_HALF (MIN_HALF)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (sclk_en),
    .half_div (half_div),
    .sclk     (scan_clk),
    .tick     (tick)
  );

  lscan_seq #(
    .NPIX  (NPIX),
    .LP_W  (LP_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .line_period (line_period),
    .tick        (tick),
    .si          (scan_start),
    .busy        (busy),
    .ev_start    (ev_start),
    .ev_pix      (ev_pix),
    .ev_num      (ev_num),
    .ev_done     (ev_done)
  );

  lscan_strobe #(
    .IDX_W   (IDX_W),
    .SMP_DLY (SMP_DLY)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_pix),
    .num       (ev_num),
    .pix_valid (pix_valid),
    .pix_index (pix_index)
  );

  // Line markers line up with the cycle the sensor clock goes high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_start <= ev_start;
      frame_done  <= ev_done;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ((pix_index != '0) && (pix_index <= NPIX_I))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($rose(scan_clk) && !$past(frame_done))); // R4

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($rose(scan_clk) && !frame_done)); // R8

endmodule

// File: tb/test_lscan_readout.sv
module test_lscan_readout;

  localparam int NPIX    = 128;
  localparam int DIV_W   = 8;
  localparam int LP_W    = 12;
  localparam int SMP_DLY = 3;
  localparam int IDX_W   = $clog2(NPIX + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd5;
  logic [LP_W-1:0]  line_period = 12'd200;
  logic             scan_clk, scan_start, pix_valid, frame_start, frame_done;
  logic [IDX_W-1:0] pix_index;

  always #4 clk = ~clk;

  lscan_readout #(
    .SYS_HZ      (40_000_000),
    .MAX_SCLK_HZ (5_000_000),
    .NPIX        (NPIX),
    .DIV_W       (DIV_W),
    .LP_W        (LP_W),
    .SMP_DLY     (SMP_DLY)
  ) i_lscan_readout (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .half_div    (half_div),
    .line_period (line_period),
    .scan_clk    (scan_clk),
    .scan_start  (scan_start),
    .pix_valid   (pix_valid),
    .pix_index   (pix_index),
    .frame_start (frame_start),
    .frame_done  (frame_done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- port monitor ----------------
  int cyc = 0, last_tog = 0;
  bit prev_clk = 0, prev_si = 0, pend = 0;
  int half_min, half_max, sp_min, sp_max, n_sp;
  int since_start, edge_in_line = 0, pix_in_line, si_rises;
  int lines_started, lines_done, rises_total;
  int fs_bad, fd_bad, pix_bad, si_bad, line_bad;
  int exp_cyc, exp_idx;

  task automatic clear_stats();
    half_min = 1_000_000; half_max = 0;
    sp_min = 1_000_000; sp_max = 0; n_sp = 0;
    lines_started = 0; lines_done = 0; rises_total = 0;
    fs_bad = 0; fd_bad = 0; pix_bad = 0; si_bad = 0; line_bad = 0;
  endtask

  always @(negedge clk) begin
    int hl, sp;
    if (!rst_n) begin
      prev_clk = 0; prev_si = 0; pend = 0; edge_in_line = 0;
    end else begin
      cyc++;
      if (pend && cyc == exp_cyc) begin
        if (pix_valid && int'(pix_index) == exp_idx) pix_in_line++;
        else pix_bad++;
        pend = 0;
      end else if (pix_valid) begin
        pix_bad++;
      end
      if (scan_start && !prev_si) si_rises = 0;
      if (!scan_start && prev_si && si_rises != 1) si_bad++;
      if (scan_clk != prev_clk) begin
        if (edge_in_line >= 1 && edge_in_line <= NPIX) begin
          hl = cyc - last_tog;
          if (hl < half_min) half_min = hl;
          if (hl > half_max) half_max = hl;
        end
        last_tog = cyc;
      end
      if (scan_clk && !prev_clk) begin
        rises_total++;
        if (scan_start) begin
          if (lines_started > 0) begin
            sp = since_start + 1;
            if (sp < sp_min) sp_min = sp;
            if (sp > sp_max) sp_max = sp;
            n_sp++;
          end
          since_start = 0; edge_in_line = 1; pix_in_line = 0;
          lines_started++; si_rises++;
          if (!frame_start) fs_bad++;
        end else begin
          since_start++;
          if (edge_in_line > 0 && edge_in_line < 1000) edge_in_line++;
          if (frame_start) fs_bad++;
        end
        if (edge_in_line >= 1 && edge_in_line <= NPIX) begin
          pend = 1; exp_cyc = cyc + SMP_DLY; exp_idx = edge_in_line;
        end
        if (edge_in_line == NPIX + 1 && !scan_start) begin
          if (!frame_done) fd_bad++;
          else begin
            lines_done++;
            if (pix_in_line != NPIX) line_bad++;
          end
        end else if (frame_done) begin
          fd_bad++;
        end
      end else begin
        if (frame_start) fs_bad++;
        if (frame_done) fd_bad++;
      end
      prev_clk = scan_clk; prev_si = scan_start;
    end
  end

  // ---------------- scenarios ----------------
  task automatic check_quiet(input string req);
    int r0;
    r0 = rises_total;
    repeat (300) @(negedge clk);
    chk_eq(req, "rising edges after stop", rises_total - r0, 0);
    chk_eq(req, "scan_clk idle level", int'(scan_clk), 0);
    chk_eq(req, "scan_start idle level", int'(scan_start), 0);
  endtask

  task automatic t_reset();
    run = 1'b1;
    repeat (10) @(negedge clk);
    chk_eq("R1", "scan_clk in reset", int'(scan_clk), 0);
    chk_eq("R1", "scan_start in reset", int'(scan_start), 0);
    chk_eq("R1", "pix_valid in reset", int'(pix_valid), 0);
    chk_eq("R1", "pix_index in reset", int'(pix_index), 0);
    chk_eq("R1", "frame markers in reset", int'(frame_start) + int'(frame_done), 0);
    run = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_lines(input int hd, input int lp, input int n, input int exp_half, input int exp_sp);
    clear_stats();
    half_div = DIV_W'(hd);
    line_period = LP_W'(lp);
    @(negedge clk);
    run = 1'b1;
    while (lines_done < n) @(negedge clk);
    run = 1'b0;
    repeat (100) @(negedge clk);
    chk_eq("R2", "shortest half period", half_min, exp_half);
    chk_eq("R2", "longest half period", half_max, exp_half);
    chk_eq("R6", "shortest start spacing", sp_min, exp_sp);
    chk_eq("R6", "longest start spacing", sp_max, exp_sp);
    chk_eq("R6", "spacings seen", n_sp, n - 1);
    chk_eq("R3", "start pulses not spanning one edge", si_bad, 0);
    chk_eq("R5", "misplaced pixel strobes", pix_bad, 0);
    chk_eq("R5", "lines without 128 pixels", line_bad, 0);
    chk_eq("R4", "misplaced frame_done", fd_bad, 0);
    chk_eq("R8", "misplaced frame_start", fs_bad, 0);
    chk_eq("R7", "lines started after stop", lines_started, n);
    check_quiet("R7");
  endtask

  task automatic t_stop_mid_line();
    clear_stats();
    half_div = 8'd4;
    line_period = 12'd200;
    @(negedge clk);
    run = 1'b1;
    while (!(lines_started == 1 && edge_in_line == 60)) @(negedge clk);
    run = 1'b0;
    repeat (69 * 8 + 200) @(negedge clk);
    chk_eq("R7", "line completed after stop", lines_done, 1);
    chk_eq("R7", "no new line after stop", lines_started, 1);
    chk_eq("R5", "pixels in stopped line", line_bad + pix_bad, 0);
    chk_eq("R3", "start pulse shape", si_bad, 0);
    check_quiet("R7");
  endtask

  initial begin
    clear_stats();
    t_reset();
    t_lines(5, 200, 3, 5, 199);   // plain divider, long period
    t_lines(1, 130, 3, 4, 129);   // divider clamp, tightest legal restart
    t_lines(7, 50, 2, 7, 129);    // period below minimum clamps to 130
    t_lines(0, 300, 2, 4, 299);   // zero divider clamps, long integration
    t_stop_mid_line();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200_000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule